// File: doc/BRIEF.md
# Block-Wide Conditional Halving Stage

This unit sits at the output of one transform stage and decides, once per block, whether the whole block must be halved to keep the next stage in range. It takes a burst of complex words, one per cycle, and stores them in a single-bank buffer. As each word arrives, its real and imaginary parts are tested against a magnitude bound. One flag collects the result over the block: a single word out of range is enough to set it.

When the last word of the block has been stored, the buffer is played back in arrival order. If the flag is set, every word is shifted right by one bit with floor rounding. If it is clear, every word leaves exactly as it came in and keeps its low bit. A per-block scale flag and a running block-exponent count go out with the readout. Because the buffer has one bank, the input is held off while the readout is running.

The bound can be set by parameter to one of two values. The half-scale bound is cheap, because it needs only the two top bits of each word. The bound near 1/sqrt(2) leaves room for a later unit-magnitude rotation.

Top module: `bfs_block_scaler`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid is 0, in_ready is 1 and out_exp is 0.
- R2: A word is accepted on a rising clock edge when in_valid and in_ready are both 1. After DEPTH words have been accepted, out_valid rises on the next cycle and stays high for exactly DEPTH cycles. The words come out in arrival order. out_first marks the first of these cycles and out_last marks the last.
- R3: If no real or imaginary part in the block is out of range, every output word equals its input word and out_scaled is 0 for the whole readout.
- R4: If any real or imaginary part in the block is out of range, every word of the block is halved and out_scaled is 1 for the whole readout.
- R5: With THR_SEL=0, a two's-complement part x of WIDTH bits is out of range when x >= 2^(WIDTH-2) or x < -2^(WIDTH-2). For WIDTH=8, the values 64 and -65 are out of range, and 63 and -64 are not.
- R6: With THR_SEL=1, let L = floor(2^(WIDTH-1)*181/256). A part is out of range when x > L or x < -L. For WIDTH=8, L is 90: the values 90 and -90 are in range, and 91 and -91 are not.
- R7: Halving is an arithmetic right shift by one bit, which rounds toward negative infinity: -3 gives -2, -1 gives -1, 3 gives 1 and -128 gives -64.
- R8: out_exp equals the number of halved blocks since reset, counted modulo 2^EXP_W and including the block now being read out. It and out_scaled stay constant across one readout.
- R9: in_ready is 0 throughout the readout. in_valid and the input data presented during that time have no effect on any later block.
- R10: The out-of-range flag starts clear for every block, so an unscaled block that follows a halved block comes out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The input word is present |
| in_ready | output | 1 | High while the buffer is filling |
| in_re | input | WIDTH | Real part of the input, two's complement |
| in_im | input | WIDTH | Imaginary part of the input, two's complement |
| out_valid | output | 1 | A readout word is present |
| out_re | output | WIDTH | Real part of the output, possibly halved |
| out_im | output | WIDTH | Imaginary part of the output, possibly halved |
| out_first | output | 1 | First word of the readout |
| out_last | output | 1 | Last word of the readout |
| out_scaled | output | 1 | The current block was halved |
| out_exp | output | EXP_W | Count of halved blocks since reset, including the current block |

## Verification
Each test block is a ramp of small values with a single spike word placed at the start, in the middle or at the end. The spike sits just inside or just outside a bound, on either the real or the imaginary part. Two instances, one for each bound, receive the same blocks. This shows that one word at any position decides for the whole block, and that the two bounds disagree exactly between 64 and 91 in magnitude. Odd negative ramps and a full-scale negative spike show the floor rounding. A readout with junk data held on the input shows that data offered during a readout is ignored. A long run of halved blocks shows the exponent count wrapping.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    typedef enum logic {
        PH_FILL  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;

    // Numerator of the ~1/sqrt(2) bound over 256.
    localparam int unsigned RT_HALF_NUM = 181;

endpackage

// File: rtl/bfs_range_check.sv
module bfs_range_check #(
    parameter int WIDTH   = 8,
    parameter int THR_SEL = 0
) (
    input  logic [WIDTH-1:0] word,
    output logic             over
);
    import bfs_pkg::*;

    generate
        if (THR_SEL == 0) begin : g_half
            // Out of [-0.5, 0.5) exactly when the two top bits differ.
            assign over = word[WIDTH-1] ^ word[WIDTH-2];
        end else begin : g_rt_half
            localparam int LIM = ((1 << (WIDTH-1)) * RT_HALF_NUM) / 256;
            localparam logic signed [WIDTH-1:0] LIM_P = WIDTH'(LIM);
            localparam logic signed [WIDTH-1:0] LIM_N = WIDTH'(-LIM);
            assign over = ($signed(word) > LIM_P) || ($signed(word) < LIM_N);
        end
    endgenerate

endmodule

// File: rtl/bfs_block_buf.sv
module bfs_block_buf #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/bfs_halver.sv
module bfs_halver #(
    parameter int WIDTH = 8,
    parameter int LANES = 2
) (
    input  logic                        en,
    input  logic [LANES-1:0][WIDTH-1:0] din,
    output logic [LANES-1:0][WIDTH-1:0] dout
);
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            // Arithmetic shift: replicate sign, drop LSB (floor rounding).
            assign dout[g] = en ? {din[g][WIDTH-1], din[g][WIDTH-1:1]} : din[g];
        end
    endgenerate

endmodule

// File: rtl/bfs_block_scaler.sv
module bfs_block_scaler #(
    parameter int WIDTH   = 8,
    parameter int DEPTH   = 16,
    parameter int EXP_W   = 4,
    parameter int THR_SEL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_re,
    input  logic [WIDTH-1:0] in_im,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_re,
    output logic [WIDTH-1:0] out_im,
    output logic             out_first,
    output logic             out_last,
    output logic             out_scaled,
    output logic [EXP_W-1:0] out_exp
);
    import bfs_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        phase_e          phase;
        logic [AW-1:0]   wr_idx;
        logic [AW-1:0]   rd_idx;
        logic            flag;
        logic [EXP_W-1:0] expc;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [1:0]            hit;
    logic                  hit_any;
    logic                  accept;
    logic [2*WIDTH-1:0]    rd_word;
    logic [1:0][WIDTH-1:0] raw_pair;
    logic [1:0][WIDTH-1:0] out_pair;

    // Per-part range detectors (real = lane 0, imaginary = lane 1).
    bfs_range_check #(.WIDTH(WIDTH), .THR_SEL(THR_SEL)) u_chk_re (
        .word (in_re),
        .over (hit[0])
    );
    bfs_range_check #(.WIDTH(WIDTH), .THR_SEL(THR_SEL)) u_chk_im (
        .word (in_im),
        .over (hit[1])
    );
    assign hit_any = |hit;

    assign accept = in_valid && (ctl_q.phase == PH_FILL);

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.phase)
            PH_FILL: begin
                if (accept) begin
                    ctl_d.flag = ctl_q.flag | hit_any;
                    if (ctl_q.wr_idx == LAST) begin
                        ctl_d.wr_idx = '0;
                        ctl_d.rd_idx = '0;
                        ctl_d.phase  = PH_DRAIN;
                        if (ctl_q.flag | hit_any) begin
                            ctl_d.expc = ctl_q.expc + EXP_W'(1);
                        end
                    end else begin
                        ctl_d.wr_idx = ctl_q.wr_idx + AW'(1);
                    end
                end
            end
            PH_DRAIN: begin
                if (ctl_q.rd_idx == LAST) begin
                    ctl_d.phase  = PH_FILL;
                    ctl_d.rd_idx = '0;
                    ctl_d.flag   = 1'b0;
                end else begin
                    ctl_d.rd_idx = ctl_q.rd_idx + AW'(1);
                end
            end
            default: ctl_d.phase = PH_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_FILL, wr_idx: '0, rd_idx: '0, flag: 1'b0, expc: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    bfs_block_buf #(.DW(2*WIDTH), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (accept),
        .waddr (ctl_q.wr_idx),
        .wdata ({in_im, in_re}),
        .raddr (ctl_q.rd_idx),
        .rdata (rd_word)
    );

    assign raw_pair[0] = rd_word[WIDTH-1:0];
    assign raw_pair[1] = rd_word[2*WIDTH-1:WIDTH];

    bfs_halver #(.WIDTH(WIDTH), .LANES(2)) u_half (
        .en   (ctl_q.flag),
        .din  (raw_pair),
        .dout (out_pair)
    );

    assign in_ready   = (ctl_q.phase == PH_FILL);
    assign out_valid  = (ctl_q.phase == PH_DRAIN);
    assign out_first  = out_valid && (ctl_q.rd_idx == '0);
    assign out_last   = out_valid && (ctl_q.rd_idx == LAST);
    assign out_scaled = out_valid && ctl_q.flag;
    assign out_exp    = ctl_q.expc;
    assign out_re     = out_pair[0];
    assign out_im     = out_pair[1];

    // R2: readout begins on the cycle after the last word is taken.
    p_drain_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && ctl_q.wr_idx == LAST) |=> (out_valid && out_first));

    // R9: no input accepted while a readout is still running.
    p_no_accept_in_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> !in_ready);

    // R8: per-block metadata is constant across a readout.
    p_meta_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_first) |-> ($stable(out_scaled) && $stable(out_exp)));

    // R8: the exponent steps by one when a flagged block closes.
    p_exp_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ctl_q.wr_idx == LAST && (ctl_q.flag || hit_any))
        |=> (ctl_q.expc == $past(ctl_q.expc) + EXP_W'(1)));

    // R10: the decision flag is clear when a new block starts filling.
    p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |=> !ctl_q.flag);

    // R7: a halved word doubled gives back the stored word, or one less.
    p_halve_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_scaled) |->
            (({out_re, 1'b0} == {raw_pair[0][WIDTH-1], raw_pair[0]}) ||
             ({out_re, 1'b1} == {raw_pair[0][WIDTH-1], raw_pair[0]})));

endmodule

// File: tb/bfs_block_scaler_tb.sv
`timescale 1ns/1ps
module bfs_block_scaler_tb_top;

    localparam int W  = 8;
    localparam int N  = 16;
    localparam int EW = 4;
    localparam int LIM_A = 1 << (W-2);
    localparam int LIM_B = ((1 << (W-1)) * 181) / 256;

    typedef struct packed {
        logic signed [7:0] base;
        logic signed [7:0] step;
        logic [3:0]        sidx;
        logic signed [7:0] sre;
        logic signed [7:0] sim;
    } vec_t;

    // base, step, spike index, spike real, spike imag
    localparam vec_t VECS [8] = '{
        '{-8'sd8,  8'sd1,  4'd0,  8'sd63,  -8'sd64 },  // R5 inside both
        '{-8'sd8,  8'sd1,  4'd15, 8'sd64,   8'sd0  },  // R5 real over A
        '{-8'sd8,  8'sd1,  4'd7,  8'sd0,   -8'sd65 },  // R5 imag over A
        '{-8'sd8,  8'sd1,  4'd3,  8'sd90,  -8'sd90 },  // R6 edge of B
        '{-8'sd8,  8'sd1,  4'd9,  8'sd91,   8'sd0  },  // R6 real over B
        '{ 8'sd4,  8'sd1,  4'd12, 8'sd0,   -8'sd91 },  // R6 imag over B
        '{-8'sd3,  8'sd0,  4'd5, -8'sd128,  8'sd3  },  // R7 rounding
        '{ 8'sd5, -8'sd1,  4'd0,  8'sd0,    8'sd0  }   // R10 after halved
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [W-1:0] in_re = '0, in_im = '0;

    logic a_rdy, a_vld, a_first, a_last, a_sc;
    logic [W-1:0] a_re, a_im;
    logic [EW-1:0] a_exp;
    logic b_rdy, b_vld, b_first, b_last, b_sc;
    logic [W-1:0] b_re, b_im;
    logic [EW-1:0] b_exp;

    int tests = 0, fails = 0;
    int blk_re [N];
    int blk_im [N];
    int exp_a = 0, exp_b = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bfs_block_scaler #(.WIDTH(W), .DEPTH(N), .EXP_W(EW), .THR_SEL(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(a_rdy),
        .in_re(in_re), .in_im(in_im), .out_valid(a_vld), .out_re(a_re),
        .out_im(a_im), .out_first(a_first), .out_last(a_last),
        .out_scaled(a_sc), .out_exp(a_exp));

    bfs_block_scaler #(.WIDTH(W), .DEPTH(N), .EXP_W(EW), .THR_SEL(1)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(b_rdy),
        .in_re(in_re), .in_im(in_im), .out_valid(b_vld), .out_re(b_re),
        .out_im(b_im), .out_first(b_first), .out_last(b_last),
        .out_scaled(b_sc), .out_exp(b_exp));

    task automatic chk(input string what, input int act, input int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, expv);
        end
    endtask

    function automatic int half_floor(input int x);
        if (x < 0 && (x % 2) != 0) return x / 2 - 1;
        return x / 2;
    endfunction

    function automatic bit over_a(input int x);
        return (x >= LIM_A) || (x < -LIM_A);
    endfunction

    function automatic bit over_b(input int x);
        return (x > LIM_B) || (x < -LIM_B);
    endfunction

    function automatic int wrap8(input int x);
        int m;
        m = x & 8'hFF;
        return (m >= 128) ? m - 256 : m;
    endfunction

    task automatic build(input vec_t v);
        for (int i = 0; i < N; i++) begin
            blk_re[i] = wrap8(int'(v.base) + int'(v.step) * i);
            blk_im[i] = wrap8(-blk_re[i]);
        end
        blk_re[v.sidx] = int'(v.sre);
        blk_im[v.sidx] = int'(v.sim);
    endtask

    task automatic send_block();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            chk("R2 in_ready while filling", int'(a_rdy), 1);
            in_valid = 1'b1;
            in_re = W'(blk_re[i]);
            in_im = W'(blk_im[i]);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain_check(input bit junk);
        bit sa, sb;
        sa = 1'b0; sb = 1'b0;
        for (int i = 0; i < N; i++) begin
            sa |= over_a(blk_re[i]) | over_a(blk_im[i]);
            sb |= over_b(blk_re[i]) | over_b(blk_im[i]);
        end
        if (sa) exp_a = (exp_a + 1) % (1 << EW);
        if (sb) exp_b = (exp_b + 1) % (1 << EW);
        for (int i = 0; i < N; i++) begin
            chk("R2 out_valid A", int'(a_vld), 1);
            chk("R2 out_valid B", int'(b_vld), 1);
            chk("R2 out_first", int'(a_first), (i == 0) ? 1 : 0);
            chk("R2 out_last", int'(a_last), (i == N-1) ? 1 : 0);
            chk("R9 in_ready low in readout", int'(a_rdy), 0);
            chk("R3/R4/R5 scaled A", int'(a_sc), int'(sa));
            chk("R3/R4/R6 scaled B", int'(b_sc), int'(sb));
            chk("R8 exponent A", int'(a_exp), exp_a);
            chk("R8 exponent B", int'(b_exp), exp_b);
            chk("R7 real A", int'($signed(a_re)), sa ? half_floor(blk_re[i]) : blk_re[i]);
            chk("R7 imag A", int'($signed(a_im)), sa ? half_floor(blk_im[i]) : blk_im[i]);
            chk("R3 real B", int'($signed(b_re)), sb ? half_floor(blk_re[i]) : blk_re[i]);
            chk("R3 imag B", int'($signed(b_im)), sb ? half_floor(blk_im[i]) : blk_im[i]);
            if (junk && i < N-1) begin
                in_valid = 1'b1;
                in_re = 8'h7F;
                in_im = 8'h80;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
        chk("R2 readout ends", int'(a_vld), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", int'(a_vld), 0);
        chk("R1 in_ready in reset", int'(a_rdy), 1);
        chk("R1 out_exp in reset", int'(a_exp), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", int'(a_vld), 0);
        chk("R1 out_exp after reset B", int'(b_exp), 0);

        // Vector table: one block per entry.
        for (int k = 0; k < 8; k++) begin
            build(VECS[k]);
            send_block();
            drain_check(1'b0);
        end

        // R9: junk offered during readout must not enter the next block.
        build(VECS[7]);
        send_block();
        drain_check(1'b1);
        build(VECS[0]);
        send_block();
        drain_check(1'b0);

        // R8: exponent wraps after 2^EXP_W halved blocks (A has 6 so far).
        for (int k = 0; k < 10; k++) begin
            build(VECS[4]);
            send_block();
            drain_check(1'b0);
        end
        chk("R8 exponent wrapped to zero", exp_a, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule